// File: doc/BRIEF.md
# I2C Acknowledge and Clock-Stretch Controller

This block handles the acknowledge slot and the wait states of an I2C interface. It follows SCL through each nine-clock byte frame using rise and fall strobes supplied by an edge detector. It shifts in the received data bits. In transmit mode it records the acknowledge level returned by the far receiver. In receive mode it pulls SDA low during the acknowledge slot according to an acknowledge value that software sets.

Software chooses when a received byte is reported. The byte can be flagged at the eighth clock, with SCL then held low so that software can decide between ACK and NACK. It can instead be flagged at the ninth clock, with no stretch. A separate wait setting holds SCL low after each acknowledge clock until the byte is read. Without either hold, a shift register and a data register give double buffering. An overrun flag marks a byte lost because the data register was still full.

Top module: `i2c_ack_stretch`

## Requirements
- R1: `bit_cnt` is 0 after reset, start detect, stop detect or soft reset. Each accepted SCL rise adds one. The rise after count 9 gives 1.
- R2: In transmit mode (`xmit_mode`=1), the rise of the ninth clock copies `sda_in` into `ack_rcvd`. Transmit frames never load `rx_data` or set `rx_full`.
- R3: A write with `cfg_wdata[1]`=1 (unlock) copies `cfg_wdata[0]` into `ack_tx_val`. A write with bit 1 clear leaves `ack_tx_val` unchanged. Bit 2 selects early flagging and bit 3 selects wait mode; every write updates both.
- R4: `ack_tx_val` is cleared when `stop_det` is seen while `stop_req`=1. A stop without `stop_req` leaves it unchanged.
- R5: A soft reset clears `ack_tx_val`, `ack_rcvd`, `rx_full`, `rx_overrun`, both holds and the count. A soft reset is `soft_rst_req`=1 while `if_enable`=0. With `if_enable`=1, `soft_rst_req` has no effect.
- R6: With early flagging off, `rx_full` rises at the ninth rise and `rx_data` holds the byte, first bit in the MSB. SCL is not held after the eighth fall.
- R7: With early flagging on, `rx_full` rises at the eighth rise and `scl_hold` is 1 from the eighth fall. The hold ends in the cycle after an unlocked write. A write without unlock leaves it set.
- R8: With wait on, `scl_hold` rises at the ninth fall if the byte is unread. It ends in the cycle after `rd_strobe`.
- R9: From the eighth fall to the ninth fall in receive mode, `sda_pull_low` equals the inverse of `ack_tx_val` (0 = ACK). Outside that window, or in transmit mode, it is 0.
- R10: When a byte completes while `rx_full` is 1 and no read arrives in that cycle, `rx_overrun` is set and `rx_data` keeps the old byte.
- R11: SCL strobes are ignored while `scl_hold` is 1.
- R12: `rd_strobe` clears `rx_full` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_rise | input | 1 | One-cycle strobe on an SCL rising edge |
| scl_fall | input | 1 | One-cycle strobe on an SCL falling edge |
| sda_in | input | 1 | Sampled SDA level |
| xmit_mode | input | 1 | 1 = transmit, 0 = receive |
| start_det | input | 1 | Start condition seen |
| stop_det | input | 1 | Stop condition seen |
| stop_req | input | 1 | A stop has been requested locally |
| if_enable | input | 1 | Interface enable |
| soft_rst_req | input | 1 | Reset request |
| cfg_we | input | 1 | Control write strobe |
| cfg_wdata | input | 4 | Control write data: ack value, unlock, early flag, wait |
| rd_strobe | input | 1 | Data register read |
| rx_data | output | 8 | Received byte |
| rx_full | output | 1 | Data register holds an unread byte |
| rx_overrun | output | 1 | A byte was lost |
| ack_rcvd | output | 1 | Acknowledge level returned by the receiver |
| ack_tx_val | output | 1 | Acknowledge value to send (1 = NACK) |
| sda_pull_low | output | 1 | Request to drive SDA low |
| scl_hold | output | 1 | Request to hold SCL low |
| bit_cnt | output | 4 | SCL clock index in the current frame |

## Verification
The bench targets the switch between eighth-clock and ninth-clock flagging. A design that mixes them up flags the byte one edge early or late, or stretches when it should not. It also sends SCL edges while a hold is active. A counter that still advances would skip the acknowledge clock or fill the byte with the wrong bits. A byte that lands on a full register must leave the old data in place and set overrun. Writes to the acknowledge value without the unlock bit, stops without a stop request, and reset requests while enabled must all leave the state untouched. A design that ignores the qualifier would clear or change the acknowledge bits.

// File: rtl/i2c_ack_pkg.sv
package i2c_ack_pkg;
  localparam int CFG_W      = 4;
  localparam int CFG_ACK    = 0;
  localparam int CFG_UNLOCK = 1;
  localparam int CFG_EARLY  = 2;
  localparam int CFG_WAIT   = 3;

  // next clock index inside a frame of 'frame' clocks; wraps to 1
  function automatic int frame_next(input int cur, input int frame);
    return (cur >= frame) ? 1 : cur + 1;
  endfunction

  // true when clock index 'idx' carries a data bit
  function automatic logic is_data_clock(input int idx, input int data_w);
    return (idx >= 1) && (idx <= data_w);
  endfunction
endpackage

// File: rtl/i2c_frame_counter.sv
module i2c_frame_counter import i2c_ack_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             hold,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt,
  output logic             data_rise,
  output logic             last_rise,
  output logic             ack_rise,
  output logic             last_fall,
  output logic             ack_fall
);
  localparam int FRAME = DATA_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             rise_ok;
  logic             fall_ok;

  assign rise_ok   = scl_rise && !hold && !clear;
  assign fall_ok   = scl_fall && !hold && !clear;
  assign cnt_nxt   = CNT_W'(frame_next(int'(cnt_q), FRAME));
  assign data_rise = rise_ok && is_data_clock(int'(cnt_nxt), DATA_W);
  assign last_rise = rise_ok && (int'(cnt_nxt) == DATA_W);
  assign ack_rise  = rise_ok && (int'(cnt_nxt) == FRAME);
  assign last_fall = fall_ok && (int'(cnt_q) == DATA_W);
  assign ack_fall  = fall_ok && (int'(cnt_q) == FRAME);
  assign cnt       = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear)   cnt_q <= '0;
    else if (rise_ok) cnt_q <= cnt_nxt;
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= FRAME);

  // R1
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));

  // R11
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !clear) |=> $stable(cnt_q));
endmodule

// File: rtl/i2c_ack_regs.sv
module i2c_ack_regs import i2c_ack_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sreset,
  input  logic             xmit,
  input  logic             ack_rise,
  input  logic             sda_in,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             stop_det,
  input  logic             stop_req,
  output logic             ack_tx,
  output logic             ack_rx,
  output logic             early,
  output logic             wait_en,
  output logic             ack_wr
);
  logic stop_clr;

  assign ack_wr   = cfg_we && cfg_wdata[CFG_UNLOCK];
  assign stop_clr = stop_det && stop_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_tx <= 1'b0;
    end else if (sreset || stop_clr) begin
      ack_tx <= 1'b0;
    end else if (ack_wr) begin
      ack_tx <= cfg_wdata[CFG_ACK];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ack_rx <= 1'b0;
    else if (sreset)            ack_rx <= 1'b0;
    else if (xmit && ack_rise)  ack_rx <= sda_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      early   <= 1'b0;
      wait_en <= 1'b0;
    end else if (cfg_we) begin
      early   <= cfg_wdata[CFG_EARLY];
      wait_en <= cfg_wdata[CFG_WAIT];
    end
  end

  // R3
  ack_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_wdata[CFG_UNLOCK] && !sreset && !stop_clr) |=> $stable(ack_tx));

  // R4
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_clr |=> !ack_tx);

  // R5
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sreset |=> (!ack_tx && !ack_rx));

  // R2
  ack_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xmit && ack_rise && !sreset) |=> (ack_rx == $past(sda_in)));
endmodule

// File: rtl/i2c_rx_buffer.sv
module i2c_rx_buffer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sreset,
  input  logic              xmit,
  input  logic              early,
  input  logic              sda_in,
  input  logic              data_rise,
  input  logic              last_rise,
  input  logic              ack_rise,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              overrun
);
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] shreg_nxt;
  logic              load;
  logic              accept;

  assign shreg_nxt = {shreg[DATA_W-2:0], sda_in};
  assign load      = !xmit && ((early && last_rise) || (!early && ack_rise));
  assign accept    = load && (!rx_full || rd_strobe);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  shreg <= '0;
    else if (data_rise && !xmit) shreg <= shreg_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rx_data <= '0;
    else if (accept) rx_data <= early ? shreg_nxt : shreg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rx_full <= 1'b0;
    else if (sreset)    rx_full <= 1'b0;
    else if (accept)    rx_full <= 1'b1;
    else if (rd_strobe) rx_full <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 overrun <= 1'b0;
    else if (sreset)            overrun <= 1'b0;
    else if (load && !accept)   overrun <= 1'b1;
  end

  // R10
  keep_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && rx_full && !rd_strobe) |=> ($stable(rx_data) && overrun));

  // R12
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !load) |=> !rx_full);

  // R2
  no_tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xmit && !rd_strobe && !sreset) |=> $stable(rx_data));
endmodule

// File: rtl/i2c_hold_ctrl.sv
module i2c_hold_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic xmit,
  input  logic early,
  input  logic wait_en,
  input  logic last_fall,
  input  logic ack_fall,
  input  logic ack_wr,
  input  logic rd_strobe,
  input  logic rx_full,
  input  logic ack_tx,
  output logic scl_hold,
  output logic sda_low
);
  logic hold_ack;
  logic hold_gap;
  logic ack_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          hold_ack <= 1'b0;
    else if (clear)                      hold_ack <= 1'b0;
    else if (last_fall && early && !xmit) hold_ack <= 1'b1;
    else if (ack_wr)                     hold_ack <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_gap <= 1'b0;
    else if (clear)  hold_gap <= 1'b0;
    else if (ack_fall && wait_en && !xmit && rx_full && !rd_strobe)
                     hold_gap <= 1'b1;
    else if (rd_strobe) hold_gap <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ack_slot <= 1'b0;
    else if (clear)     ack_slot <= 1'b0;
    else if (last_fall) ack_slot <= 1'b1;
    else if (ack_fall)  ack_slot <= 1'b0;
  end

  assign scl_hold = hold_ack || hold_gap;
  assign sda_low  = ack_slot && !xmit && !ack_tx;

  // R7
  ack_hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack && !ack_wr && !clear) |=> hold_ack);

  // R7
  ack_hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack && ack_wr) |=> !hold_ack);

  // R8
  gap_hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_gap && !rd_strobe && !clear) |=> hold_gap);

  // R9
  no_tx_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xmit |-> !sda_low);
endmodule

// File: rtl/i2c_ack_stretch.sv
module i2c_ack_stretch import i2c_ack_pkg::*; #(
  parameter  int DATA_W = 8,
  localparam int CNT_W  = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_in,
  input  logic              xmit_mode,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              stop_req,
  input  logic              if_enable,
  input  logic              soft_rst_req,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_overrun,
  output logic              ack_rcvd,
  output logic              ack_tx_val,
  output logic              sda_pull_low,
  output logic              scl_hold,
  output logic [CNT_W-1:0]  bit_cnt
);
  logic sreset;
  logic frame_clear;
  logic data_rise, last_rise, ack_rise, last_fall, ack_fall;
  logic early, wait_en, ack_wr;

  assign sreset      = soft_rst_req && !if_enable;
  assign frame_clear = start_det || stop_det || sreset;

  i2c_frame_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .hold(scl_hold), .clear(frame_clear), .cnt(bit_cnt),
    .data_rise(data_rise), .last_rise(last_rise), .ack_rise(ack_rise),
    .last_fall(last_fall), .ack_fall(ack_fall)
  );

  i2c_ack_regs u_regs (
    .clk(clk), .rst_n(rst_n), .sreset(sreset), .xmit(xmit_mode),
    .ack_rise(ack_rise), .sda_in(sda_in), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .stop_det(stop_det), .stop_req(stop_req),
    .ack_tx(ack_tx_val), .ack_rx(ack_rcvd), .early(early),
    .wait_en(wait_en), .ack_wr(ack_wr)
  );

  i2c_rx_buffer #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .sreset(sreset), .xmit(xmit_mode),
    .early(early), .sda_in(sda_in), .data_rise(data_rise),
    .last_rise(last_rise), .ack_rise(ack_rise), .rd_strobe(rd_strobe),
    .rx_data(rx_data), .rx_full(rx_full), .overrun(rx_overrun)
  );

  i2c_hold_ctrl u_hold (
    .clk(clk), .rst_n(rst_n), .clear(frame_clear), .xmit(xmit_mode),
    .early(early), .wait_en(wait_en), .last_fall(last_fall),
    .ack_fall(ack_fall), .ack_wr(ack_wr), .rd_strobe(rd_strobe),
    .rx_full(rx_full), .ack_tx(ack_tx_val), .scl_hold(scl_hold),
    .sda_low(sda_pull_low)
  );

  // R5
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sreset |=> (!rx_full && !rx_overrun && !scl_hold && bit_cnt == '0));

  // R6
  late_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!early && !wait_en && !scl_hold) |=> !scl_hold);
endmodule

// File: tb/test_i2c_ack_stretch.sv
module test_i2c_ack_stretch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_rise = 0, scl_fall = 0, sda_in = 0, xmit_mode = 0;
  logic       start_det = 0, stop_det = 0, stop_req = 0;
  logic       if_enable = 1, soft_rst_req = 0, cfg_we = 0, rd_strobe = 0;
  logic [3:0] cfg_wdata = '0;
  logic [7:0] rx_data;
  logic       rx_full, rx_overrun, ack_rcvd, ack_tx_val, sda_pull_low, scl_hold;
  logic [3:0] bit_cnt;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_q[$];
  logic prev_full = 1'b0;

  always #5 clk = ~clk;

  i2c_ack_stretch i_i2c_ack_stretch (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_in(sda_in), .xmit_mode(xmit_mode), .start_det(start_det),
    .stop_det(stop_det), .stop_req(stop_req), .if_enable(if_enable),
    .soft_rst_req(soft_rst_req), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_full(rx_full),
    .rx_overrun(rx_overrun), .ack_rcvd(ack_rcvd), .ack_tx_val(ack_tx_val),
    .sda_pull_low(sda_pull_low), .scl_hold(scl_hold), .bit_cnt(bit_cnt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: every new byte in the data register is compared with the queue
  always @(negedge clk) begin
    if (rst_n && rx_full && !prev_full) begin
      if (exp_q.size() == 0) chk("R6/R7 unexpected byte", {24'd0, rx_data}, 32'hffff);
      else chk("R6/R7 scoreboard byte", {24'd0, rx_data}, {24'd0, exp_q.pop_front()});
    end
    prev_full = rx_full;
  end

  task automatic rise(input logic b);
    @(negedge clk); sda_in = b; scl_rise = 1'b1;
    @(negedge clk); scl_rise = 1'b0;
  endtask

  task automatic fall();
    @(negedge clk); scl_fall = 1'b1;
    @(negedge clk); scl_fall = 1'b0;
  endtask

  task automatic run(input logic [7:0] b, input logic ackb, input int k0, input int k1);
    for (int k = k0; k <= k1; k++) begin
      rise((k <= 8) ? b[8-k] : ackb);
      fall();
    end
  endtask

  task automatic wr(input logic [3:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset count", bit_cnt, 0);
    chk("R5 reset full", rx_full, 0);
    chk("R5 reset hold", scl_hold, 0);
    chk("R5 reset ack_tx", ack_tx_val, 0);

    // R3 write protection of the acknowledge value
    wr(4'b0001); chk("R3 locked write", ack_tx_val, 0);
    wr(4'b0011); chk("R3 unlocked write 1", ack_tx_val, 1);
    wr(4'b0010); chk("R3 unlocked write 0", ack_tx_val, 0);

    // ninth-clock flagging, no stretch
    exp_q.push_back(8'hA5);
    run(8'hA5, 1'b0, 1, 7);
    chk("R1 count after 7", bit_cnt, 7);
    rise(1'b1);
    chk("R6 not full at 8th rise", rx_full, 0);
    fall();
    chk("R6 no hold after 8th fall", scl_hold, 0);
    chk("R9 ACK driven in slot", sda_pull_low, 1);
    rise(1'b0);
    chk("R6 full at 9th rise", rx_full, 1);
    chk("R1 count 9", bit_cnt, 9);
    fall();
    chk("R9 released after 9th fall", sda_pull_low, 0);
    rd();
    chk("R12 read clears full", rx_full, 0);

    // overrun
    exp_q.push_back(8'h3C);
    run(8'h3C, 1'b0, 1, 9);
    rise(1'b0);
    chk("R1 wrap to 1", bit_cnt, 1);
    fall();
    run(8'h77, 1'b0, 2, 9);
    chk("R10 overrun set", rx_overrun, 1);
    chk("R10 old byte kept", rx_data, 8'h3C);
    rd();
    chk("R12 read after overrun", rx_full, 0);

    // eighth-clock flagging with hold
    wr(4'b0110);
    exp_q.push_back(8'h5A);
    run(8'h5A, 1'b0, 1, 7);
    rise(1'b0);
    chk("R7 full at 8th rise", rx_full, 1);
    fall();
    chk("R7 hold after 8th fall", scl_hold, 1);
    rise(1'b1);
    chk("R11 rise ignored while held", bit_cnt, 8);
    wr(4'b0100);
    chk("R7 locked write keeps hold", scl_hold, 1);
    wr(4'b0111);
    chk("R7 unlocked write releases", scl_hold, 0);
    chk("R9 NACK leaves SDA", sda_pull_low, 0);
    rise(1'b0); fall();
    rd();

    // wait mode
    wr(4'b1010);
    exp_q.push_back(8'hC3);
    run(8'hC3, 1'b0, 1, 8);
    rise(1'b0);
    fall();
    chk("R8 hold after 9th fall", scl_hold, 1);
    rise(1'b1);
    chk("R11 rise ignored in wait", bit_cnt, 9);
    rd();
    chk("R8 read releases hold", scl_hold, 0);
    chk("R12 read clears full (wait)", rx_full, 0);

    // transmit mode
    wr(4'b0010);
    xmit_mode = 1'b1;
    run(8'h00, 1'b0, 1, 8);
    chk("R9 no drive in transmit", sda_pull_low, 0);
    rise(1'b1);
    chk("R2 NACK captured", ack_rcvd, 1);
    fall();
    run(8'hFF, 1'b0, 1, 9);
    chk("R2 ACK captured", ack_rcvd, 0);
    chk("R2 transmit loads nothing", rx_full, 0);

    // start and stop
    rise(1'b0);
    @(negedge clk); start_det = 1'b1; @(negedge clk); start_det = 1'b0;
    chk("R1 start clears count", bit_cnt, 0);
    wr(4'b0011);
    @(negedge clk); stop_det = 1'b1; @(negedge clk); stop_det = 1'b0;
    chk("R4 stop without request", ack_tx_val, 1);
    chk("R1 stop clears count", bit_cnt, 0);
    stop_req = 1'b1;
    @(negedge clk); stop_det = 1'b1; @(negedge clk); stop_det = 1'b0;
    stop_req = 1'b0;
    chk("R4 stop with request", ack_tx_val, 0);

    // soft reset
    wr(4'b0011);
    run(8'h00, 1'b1, 1, 9);
    rise(1'b0);
    @(negedge clk); soft_rst_req = 1'b1; @(negedge clk); soft_rst_req = 1'b0;
    chk("R5 enabled request ignored ack_tx", ack_tx_val, 1);
    chk("R5 enabled request ignored ack_rcvd", ack_rcvd, 1);
    chk("R5 enabled request ignored count", bit_cnt, 1);
    if_enable = 1'b0;
    @(negedge clk); soft_rst_req = 1'b1; @(negedge clk); soft_rst_req = 1'b0;
    chk("R5 soft reset ack_tx", ack_tx_val, 0);
    chk("R5 soft reset ack_rcvd", ack_rcvd, 0);
    chk("R5 soft reset overrun", rx_overrun, 0);
    chk("R5 soft reset count", bit_cnt, 0);
    chk("R6/R7 scoreboard drained", exp_q.size(), 0);
    report();
  end
endmodule